// File: doc/BRIEF.md
# Round-Robin Output Refresh Sequencer

This block drives a bank of sample-and-hold outputs that share a single converter. A slow refresh oscillator sets the pace: on each of its periods exactly one output slot is serviced, in fixed rotation. While the oscillator is low, the sample switch of the serviced slot is closed and the code for that slot is presented to the converter. While it is high, every switch is open and the hold capacitors carry the outputs.

The oscillator comes from one of two sources, picked by a select input. One is an internal divider of the system clock, which is also driven out on a pad so that a second device can follow it. The other is an external pad input. That input is synchronised and qualified by a minimum pulse width, and a pulse that is too short raises an error strobe and is not counted as a period. Each slot keeps the code it last applied. On every visit that code moves toward the slot's programmed target by no more than a fixed step, so a large change settles over several full rotations. A separate common-voltage code is not part of the rotation and simply follows its register.

Top module: `refresh_sequencer`

## Requirements
- R1: While the oscillator is low after an accepted falling edge, `sw_close` is one-hot with bit `ch_index` set. It asserts on the clock after that edge is detected and clears on the clock after the matching rising edge is detected, and `refresh_strobe` pulses for exactly that first clock.
- R2: Each accepted falling edge advances `ch_index` by one, from 0 to NUM_CH-1 and then wrapping to 0. The first visit after reset services slot 0, and no slot is visited twice within one rotation.
- R3: On a visit, the applied code of the visited slot moves toward its target by STEP_CODES when the distance is larger than STEP_CODES. Otherwise it becomes exactly the target. `applied_code` shows the new value while `refresh_strobe` is high.
- R4: During reset and until the first visit, `ch_index` is NUM_CH-1, `applied_code` is 0, and `sw_close`, `refresh_strobe` and `pulse_err` are 0. All applied codes reset to 0.
- R5: With `osc_src_sel` = 0 (internal), `osc_pin_oe` is 1 and `osc_pin_out` is a square wave with a period of 2*DIV_HALF system clocks. Each of its falling edges makes one visit.
- R6: With `osc_src_sel` = 1 (external), `osc_pin_oe` is 0. A level on `osc_pin_in` counts as an edge only once it has been stable for MIN_PULSE_CLKS clocks after synchronisation.
- R7: An external pulse (high or low) shorter than MIN_PULSE_CLKS clocks raises `pulse_err` for one clock when it ends, and it makes no visit.
- R8: `vcom_code` equals `vcom_target` delayed by one clock, regardless of the rotation.
- R9: A target written between visits is used at that slot's next visit. This is at most NUM_CH+1 oscillator periods later.
- R10: Changing `osc_src_sel` never causes a visit on the clock of the change, and it opens all switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_src_sel | input | 1 | 0 selects the internal divider, 1 selects the external pad |
| osc_pin_in | input | 1 | External oscillator pad input |
| osc_pin_out | output | 1 | Internal oscillator driven toward the pad |
| osc_pin_oe | output | 1 | Pad output enable, high in internal mode |
| target_codes | input | NUM_CH*CODE_W | Programmed target per slot, slot k at bits k*CODE_W upward |
| vcom_target | input | CODE_W | Common-voltage register value |
| ch_index | output | IDX_W | Slot currently or last serviced |
| applied_code | output | CODE_W | Code presented to the shared converter |
| sw_close | output | NUM_CH | One-hot sample-switch enables |
| refresh_strobe | output | 1 | One-clock pulse at the start of each visit |
| vcom_code | output | CODE_W | Common-voltage code |
| pulse_err | output | 1 | One-clock pulse for a rejected short external pulse |

## Verification
A corrupted slot counter shows up on the very next visit as a `ch_index` outside the expected rotation, together with a `sw_close` bit that disagrees with it. A corrupted applied code first appears when that slot is next serviced, which can be up to one full rotation later, as a value that breaks the step bound or misses the target. A bad edge qualifier appears as extra or missing visits, or as an unexpected `pulse_err`, within one oscillator period of the pad activity. The scoreboard predicts every visit as the slot and code pair, so any of these faults becomes a miscompare at the strobe where it surfaces.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic {
      OSC_INTERNAL = 1'b0,
      OSC_EXTERNAL = 1'b1
   } osc_src_e;

   function automatic int unsigned code_dist(input int unsigned a, input int unsigned b);
      return (a > b) ? (a - b) : (b - a);
   endfunction

endpackage

// File: rtl/rs_int_osc.sv
module rs_int_osc #(
   parameter int DIV_HALF = 2500
) (
   input  logic clk,
   input  logic rst_n,
   output logic osc_out
);
   localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("rs_int_osc: DIV_HALF must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         osc_out <= 1'b1;
      end else if (cnt == CW'(DIV_HALF - 1)) begin
         cnt     <= '0;
         osc_out <= ~osc_out;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rs_ext_qual.sv
module rs_ext_qual #(
   parameter int MIN_PULSE_CLKS = 400,
   parameter int SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic lvl_out,
   output logic err_out
);
   localparam int RW = $clog2(MIN_PULSE_CLKS + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rs_ext_qual: SYNC_STAGES must be at least 2");
      end
      if (MIN_PULSE_CLKS < 1) begin : g_bad_min
         $error("rs_ext_qual: MIN_PULSE_CLKS must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] chain;
   logic                   s_q;
   logic [RW-1:0]          run_cnt;
   logic                   s_now;
   logic                   edge_seen;

   assign s_now     = chain[SYNC_STAGES-1];
   assign edge_seen = s_now ^ s_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '1;
         s_q   <= 1'b1;
      end else begin
         chain <= {chain[SYNC_STAGES-2:0], pin_in};
         s_q   <= s_now;
      end
   end

   // run length of the present synchronised level, saturating at the minimum
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= RW'(MIN_PULSE_CLKS);
      end else if (edge_seen) begin
         run_cnt <= RW'(1);
      end else if (run_cnt < RW'(MIN_PULSE_CLKS)) begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   // qualified level and rejection strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_out <= 1'b1;
         err_out <= 1'b0;
      end else begin
         err_out <= edge_seen && (s_q != lvl_out);
         if (!edge_seen && (s_now != lvl_out) && (run_cnt >= RW'(MIN_PULSE_CLKS)))
            lvl_out <= s_now;
      end
   end

   // R7: a rejected pulse never moves the qualified level in the same step
   p_reject_holds_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      err_out |-> $stable(lvl_out));

endmodule

// File: rtl/rs_code_bank.sv
module rs_code_bank
   import rsq_pkg::*;
#(
   parameter int NUM_CH     = 18,
   parameter int CODE_W     = 11,
   parameter int STEP_CODES = 256,
   parameter int IDX_W      = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd_en,
   input  logic [IDX_W-1:0]         upd_idx,
   input  logic [NUM_CH*CODE_W-1:0] tgt_flat,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [CODE_W-1:0]        rd_code
);
   localparam int FULL_SPAN = (1 << CODE_W) - 1;

   generate
      if (STEP_CODES < 1) begin : g_bad_step
         $error("rs_code_bank: STEP_CODES must be at least 1");
      end
   endgenerate

   logic [CODE_W-1:0] app [NUM_CH];
   logic [CODE_W-1:0] cur_code;
   logic [CODE_W-1:0] tgt_code;
   logic [CODE_W-1:0] nxt_code;
   logic              upd_ok;

   assign upd_ok = (int'(upd_idx) < NUM_CH);

   always_comb begin
      cur_code = '0;
      tgt_code = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         if (int'(upd_idx) == k) begin
            cur_code = app[k];
            tgt_code = tgt_flat[k*CODE_W +: CODE_W];
         end
      end
   end

   always_comb begin
      rd_code = '0;
      for (int k = 0; k < NUM_CH; k++)
         if (int'(rd_idx) == k) rd_code = app[k];
   end

   // one shared limiter; a step covering full span degenerates to a copy
   generate
      if (STEP_CODES >= FULL_SPAN) begin : g_direct
         assign nxt_code = tgt_code;
      end else begin : g_limited
         localparam logic signed [CODE_W+1:0] STEP_S = (CODE_W+2)'(STEP_CODES);
         logic signed [CODE_W+1:0] diff;
         assign diff = $signed({2'b00, tgt_code}) - $signed({2'b00, cur_code});
         always_comb begin
            if (diff > STEP_S)
               nxt_code = cur_code + CODE_W'(STEP_CODES);
            else if (diff < -STEP_S)
               nxt_code = cur_code - CODE_W'(STEP_CODES);
            else
               nxt_code = tgt_code;
         end
      end
   endgenerate

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               app[g] <= '0;
            else if (upd_en && upd_ok && (int'(upd_idx) == g))
               app[g] <= nxt_code;
         end

         // R3: no slot ever jumps by more than one step between clocks
         p_step_bound_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            code_dist(int'(app[g]), int'($past(app[g]))) <= STEP_CODES);
      end
   endgenerate

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
   import rsq_pkg::*;
#(
   parameter int NUM_CH         = 18,
   parameter int CODE_W         = 11,
   parameter int STEP_CODES     = 256,
   parameter int DIV_HALF       = 2500,
   parameter int MIN_PULSE_CLKS = 400,
   parameter int SYNC_STAGES    = 2,
   parameter int IDX_W          = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     osc_src_sel,
   input  logic                     osc_pin_in,
   output logic                     osc_pin_out,
   output logic                     osc_pin_oe,
   input  logic [NUM_CH*CODE_W-1:0] target_codes,
   input  logic [CODE_W-1:0]        vcom_target,
   output logic [IDX_W-1:0]         ch_index,
   output logic [CODE_W-1:0]        applied_code,
   output logic [NUM_CH-1:0]        sw_close,
   output logic                     refresh_strobe,
   output logic [CODE_W-1:0]        vcom_code,
   output logic                     pulse_err
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("refresh_sequencer: NUM_CH must be at least 2");
      end
      if (IDX_W < $clog2(NUM_CH)) begin : g_bad_idx
         $error("refresh_sequencer: IDX_W too narrow for NUM_CH");
      end
   endgenerate

   osc_src_e src_now, src_q;
   logic     int_osc;
   logic     ext_lvl;
   logic     lvl_now, lvl_q;
   logic     fall_evt, rise_evt, src_change;
   logic     serviced;
   logic [IDX_W-1:0] idx, idx_nxt;

   assign src_now = osc_src_e'(osc_src_sel);

   rs_int_osc #(.DIV_HALF(DIV_HALF)) u_int_osc (
      .clk     (clk),
      .rst_n   (rst_n),
      .osc_out (int_osc)
   );

   rs_ext_qual #(
      .MIN_PULSE_CLKS (MIN_PULSE_CLKS),
      .SYNC_STAGES    (SYNC_STAGES)
   ) u_ext_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (osc_pin_in),
      .lvl_out (ext_lvl),
      .err_out (pulse_err)
   );

   assign osc_pin_out = int_osc;
   assign osc_pin_oe  = (src_now == OSC_INTERNAL);
   assign lvl_now     = (src_now == OSC_EXTERNAL) ? ext_lvl : int_osc;
   assign src_change  = (src_now != src_q);
   assign fall_evt    = lvl_q & ~lvl_now & ~src_change;
   assign rise_evt    = ~lvl_q & lvl_now & ~src_change;
   assign idx_nxt     = (idx == LAST_IDX) ? '0 : idx + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= OSC_EXTERNAL;
         lvl_q <= 1'b1;
      end else begin
         src_q <= src_now;
         lvl_q <= lvl_now;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx            <= LAST_IDX;
         serviced       <= 1'b0;
         refresh_strobe <= 1'b0;
      end else begin
         refresh_strobe <= fall_evt;
         if (fall_evt) begin
            idx      <= idx_nxt;
            serviced <= 1'b1;
         end else if (rise_evt || src_change) begin
            serviced <= 1'b0;
         end
      end
   end

   rs_code_bank #(
      .NUM_CH     (NUM_CH),
      .CODE_W     (CODE_W),
      .STEP_CODES (STEP_CODES),
      .IDX_W      (IDX_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (fall_evt),
      .upd_idx  (idx_nxt),
      .tgt_flat (target_codes),
      .rd_idx   (idx),
      .rd_code  (applied_code)
   );

   assign ch_index = idx;

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_sw
         assign sw_close[g] = serviced && (int'(idx) == g);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) vcom_code <= '0;
      else        vcom_code <= vcom_target;
   end

   // R1: at most one sample switch closed at a time
   p_sw_onehot_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_close));

   // R2: the serviced slot stays inside the rotation
   p_idx_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      int'(ch_index) < NUM_CH);

   // R2: every visit moves exactly one slot forward with wrap
   p_idx_advance_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      refresh_strobe |-> (ch_index == (($past(ch_index) == LAST_IDX) ? '0 : $past(ch_index) + 1'b1)));

   // R10: a source change never starts a visit
   p_no_switch_visit_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (osc_src_sel != $past(osc_src_sel)) |=> !refresh_strobe);

endmodule

// File: tb/refresh_sequencer_tb.sv
module refresh_sequencer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 18;
   localparam int W    = 11;
   localparam int STEP = 256;
   localparam int DIVH = 10;
   localparam int MINP = 6;
   localparam int IW   = $clog2(N);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           osc_src_sel = 1'b1;
   logic           osc_pin_in = 1'b1;
   logic           osc_pin_out, osc_pin_oe;
   logic [N*W-1:0] tgt_bus;
   logic [W-1:0]   vcom_t = '0;
   logic [IW-1:0]  ch_index;
   logic [W-1:0]   applied_code, vcom_code;
   logic [N-1:0]   sw_close;
   logic           refresh_strobe, pulse_err;

   int mdl_tgt [N];
   int mdl_app [N];
   int mdl_idx = N - 1;
   int exp_ch[$];
   int exp_code[$];
   int vectors = 0, miscompares = 0, err_seen = 0, strobes = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   for (genvar g = 0; g < N; g++) begin : g_tgt
      assign tgt_bus[g*W +: W] = W'(mdl_tgt[g]);
   end

   refresh_sequencer #(
      .NUM_CH(N), .CODE_W(W), .STEP_CODES(STEP),
      .DIV_HALF(DIVH), .MIN_PULSE_CLKS(MINP)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .osc_src_sel(osc_src_sel), .osc_pin_in(osc_pin_in),
      .osc_pin_out(osc_pin_out), .osc_pin_oe(osc_pin_oe), .target_codes(tgt_bus),
      .vcom_target(vcom_t), .ch_index(ch_index), .applied_code(applied_code),
      .sw_close(sw_close), .refresh_strobe(refresh_strobe), .vcom_code(vcom_code),
      .pulse_err(pulse_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver side of the scoreboard: predict the next n visits
   task automatic push_visits(input int n);
      for (int k = 0; k < n; k++) begin
         int d;
         mdl_idx = (mdl_idx + 1) % N;
         d = mdl_tgt[mdl_idx] - mdl_app[mdl_idx];
         if (d > STEP)       mdl_app[mdl_idx] += STEP;
         else if (d < -STEP) mdl_app[mdl_idx] -= STEP;
         else                mdl_app[mdl_idx] = mdl_tgt[mdl_idx];
         exp_ch.push_back(mdl_idx);
         exp_code.push_back(mdl_app[mdl_idx]);
      end
   endtask

   task automatic ext_periods(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) osc_pin_in = 1'b0;
         repeat (14) @(negedge clk);
         osc_pin_in = 1'b1;
         repeat (14) @(negedge clk);
         chk(sw_close == '0, "R1 switches open in high phase", int'(sw_close), 0);
         repeat (2) @(negedge clk);
      end
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (pulse_err) err_seen++;
         if (refresh_strobe) begin
            strobes++;
            if (exp_ch.size() == 0) begin
               chk(1'b0, "R2 unexpected visit", int'(ch_index), -1);
            end else begin
               int e_ch, e_code;
               e_ch   = exp_ch.pop_front();
               e_code = exp_code.pop_front();
               chk(int'(ch_index) == e_ch, "R2 slot order", int'(ch_index), e_ch);
               chk(int'(applied_code) == e_code, "R3 applied code", int'(applied_code), e_code);
               chk(sw_close == N'(1) << e_ch, "R1 switch one-hot", int'(sw_close), 1 << e_ch);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", exp_ch.size(), 0);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int prev_strobes, prev_err, per, last;
      for (int i = 0; i < N; i++) begin
         mdl_tgt[i] = 0;
         mdl_app[i] = 0;
      end
      repeat (5) @(negedge clk);
      // R4 reset state
      chk(int'(ch_index) == N - 1, "R4 reset index", int'(ch_index), N - 1);
      chk(applied_code == '0, "R4 reset code", int'(applied_code), 0);
      chk(sw_close == '0 && !refresh_strobe && !pulse_err, "R4 reset strobes", int'(sw_close), 0);
      chk(osc_pin_oe == 1'b0, "R6 pad input in external mode", int'(osc_pin_oe), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // full-scale climbs, exact-step and one-past-step targets
      for (int i = 0; i < N; i++) mdl_tgt[i] = (i * 337 + 50) % 2048;
      mdl_tgt[0] = 2047; mdl_tgt[1] = 0; mdl_tgt[2] = 256; mdl_tgt[3] = 257;
      push_visits(9 * N);
      ext_periods(9 * N);
      repeat (5) @(negedge clk);
      chk(exp_ch.size() == 0, "R6 all external periods visited", exp_ch.size(), 0);

      // R9: retarget between visits, including a full-scale descent
      mdl_tgt[0] = 0; mdl_tgt[5] = 1000; mdl_tgt[17] = 1;
      push_visits(2 * N);
      ext_periods(2 * N);
      repeat (5) @(negedge clk);
      chk(exp_ch.size() == 0, "R9 retarget visits", exp_ch.size(), 0);

      // R7: short low pulse during the high phase
      prev_strobes = strobes;
      prev_err = err_seen;
      @(negedge clk) osc_pin_in = 1'b0;
      repeat (3) @(negedge clk);
      osc_pin_in = 1'b1;
      repeat (20) @(negedge clk);
      chk(err_seen == prev_err + 1, "R7 short pulse flagged", err_seen - prev_err, 1);
      chk(strobes == prev_strobes, "R7 short pulse made no visit", strobes - prev_strobes, 0);
      push_visits(2);
      ext_periods(2);
      chk(err_seen == prev_err + 1, "R7 normal pulses not flagged", err_seen - prev_err, 1);

      // R8: common-voltage code
      @(negedge clk) vcom_t = 11'd1234;
      @(negedge clk);
      chk(int'(vcom_code) == 1234, "R8 vcom follows", int'(vcom_code), 1234);

      // R5 / R10: switch to the internal divider
      push_visits(N + 3);
      @(negedge clk) osc_src_sel = 1'b0;
      @(negedge clk);
      chk(osc_pin_oe == 1'b1, "R5 pad driven in internal mode", int'(osc_pin_oe), 1);
      last = int'(osc_pin_out);
      while (!(last == 0 && osc_pin_out == 1'b1)) begin
         last = int'(osc_pin_out);
         @(negedge clk);
      end
      per = 0;
      last = 1;
      do begin
         last = int'(osc_pin_out);
         @(negedge clk);
         per++;
      end while (!(last == 0 && osc_pin_out == 1'b1));
      chk(per == 2 * DIVH, "R5 internal period", per, 2 * DIVH);
      for (int t = 0; t < 5000 && exp_ch.size() != 0; t++) @(posedge clk);
      chk(exp_ch.size() == 0, "R5 internal visits", exp_ch.size(), 0);
      @(negedge clk) osc_src_sel = 1'b1;
      repeat (3) @(negedge clk);
      chk(sw_close == '0, "R10 switches opened on source change", int'(sw_close), 0);

      // back on the external pad, the rotation continues
      push_visits(N);
      ext_periods(N);
      repeat (5) @(negedge clk);
      chk(exp_ch.size() == 0, "R2 rotation after source change", exp_ch.size(), 0);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule